// File: doc/BRIEF.md
# Circular Reorder Buffer with Shared Result Buses

The block holds in-flight speculative instructions in program order and retires them in the same order. Storage is a ring of NR slots addressed by a head pointer (oldest) and a tail pointer (next free). At dispatch, up to NW instructions are accepted together. Each accepted instruction receives the index of its slot as its tag. Execution units return results on NB shared result buses. Each bus carries a tag, a data word, an exception flag and a mispredict flag, and the addressed slot is marked done.

Retirement uses the same NB buses. Writeback traffic has priority. Commit may use only the buses left idle in that cycle, starting at the head and stopping at the first slot that is not done. When a retiring branch carries the mispredict flag, every younger slot is discarded and both pointers move to the slot after the branch. A separate flush input empties the whole ring. Two running statistics are kept: cycles lost to dispatch stalls, and the number of bus transfers.

Top module: `rob_top`

## Requirements
- R1: After reset the buffer is empty (`empty_o`=1, `full_o`=0), `disp_ready_o` is 1, no commit lane is valid, and `stall_cnt_o`, `bus_used_o` and `util_total_o` are 0.
- R2: In a cycle where dispatch is accepted, a valid dispatch lane i gets tag (tail + number of valid lanes below i) mod NR. The tail advances by the number of valid lanes.
- R3: When the number of valid dispatch lanes exceeds NR minus occupancy, and no flush or redirect is happening, nothing is allocated and `disp_ready_o` is 0. `stall_cnt_o` also rises by exactly 1 in the following cycle. No other cycle changes `stall_cnt_o`.
- R4: Occupancy is tracked as a count. `empty_o` is 1 exactly when it is 0, and `full_o` is 1 exactly when it equals NR, including when head equals tail.
- R5: A valid writeback on any bus marks the tagged slot done and stores its data, exception flag and mispredict flag. A slot becomes eligible for commit in the cycle after its writeback.
- R6: Commit lane k may be valid only if k < NB minus the number of valid writeback buses. Lanes fill from the head in order and stop at the first slot that is not done, or at the end of the occupied slots.
- R7: A valid commit lane presents the tag, destination register, data and exception flag of its slot.
- R8: When a committing slot has its mispredict flag set, that lane commits and `redirect_o` is 1. All later lanes are invalid. The buffer is empty in the next cycle, with head and tail at the branch tag plus 1. Dispatch is not accepted in that cycle and no stall is counted.
- R9: While `flush_i` is 1 there is no commit and no dispatch, and no stall is counted. The buffer is empty in the next cycle, and the tail is placed at the head.
- R10: `bus_used_o` equals the number of valid writeback buses plus the number of valid commit lanes, and never exceeds NB. `util_total_o` accumulates `bus_used_o` once per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| flush_i | input | 1 | Discard all entries |
| disp_valid_i | input | NW | Dispatch lane valid |
| disp_dst_i | input | NW x REG_W | Destination register per lane |
| disp_ready_o | output | 1 | Dispatch group accepted this cycle |
| disp_tag_o | output | NW x IW | Tag given to each valid lane |
| wb_valid_i | input | NB | Writeback bus valid |
| wb_tag_i | input | NB x IW | Writeback target tag |
| wb_data_i | input | NB x DATA_W | Writeback result |
| wb_exc_i | input | NB | Exception flag |
| wb_mis_i | input | NB | Branch mispredict flag |
| full_o | output | 1 | Occupancy equals NR |
| empty_o | output | 1 | Occupancy is zero |
| cmt_valid_o | output | NB | Commit lane valid |
| cmt_tag_o | output | NB x IW | Tag of the committing slot |
| cmt_dst_o | output | NB x REG_W | Destination register write index |
| cmt_data_o | output | NB x DATA_W | Register write data |
| cmt_exc_o | output | NB | Exception flag of the committing slot |
| redirect_o | output | 1 | A mispredicted branch retires this cycle |
| stall_cnt_o | output | 32 | Dispatch stall cycles |
| bus_used_o | output | clog2(NB+1) | Buses carrying a transfer this cycle |
| util_total_o | output | 32 | Accumulated bus transfers |

## Verification
The bench builds the block with NR=8, NW=4 and NB=3. The small ring fills after a few dispatch groups, so full, stall and pointer wrap occur many times in a short run. Because NB is odd and smaller than NW, the number of commit lanes left free by writeback ranges over every value from zero to three, including cycles where writeback takes every bus. The bench mixes a drain phase and a fill phase with rare mispredicted branches and flushes. Redirects and flushes therefore occur with the ring empty, partly full and full, and with the branch in different commit lanes.

// File: rtl/rob_pkg.sv
package rob_pkg;
  parameter int DATA_W = 32;
  parameter int REG_W  = 5;

  typedef struct packed {
    logic              done;
    logic              exc;
    logic              mis;
    logic [REG_W-1:0]  dst;
    logic [DATA_W-1:0] data;
  } rob_entry_t;
endpackage

// File: rtl/rob_alloc.sv
module rob_alloc #(
  parameter int NR = 16,
  parameter int NW = 4,
  localparam int IW = $clog2(NR),
  localparam int CW = $clog2(NR + 1)
) (
  input  logic [IW-1:0]          tail_i,
  input  logic [CW-1:0]          cnt_i,
  input  logic [NW-1:0]          valid_i,
  input  logic                   block_i,
  output logic [NW-1:0][IW-1:0]  tag_o,
  output logic [CW-1:0]          n_alloc_o,
  output logic                   ready_o,
  output logic                   stall_o
);
  int rank;
  int free_n;

  always_comb begin
    rank = 0;
    for (int i = 0; i < NW; i++) begin
      tag_o[i] = tail_i + IW'(rank);
      if (valid_i[i]) rank = rank + 1;
    end
    free_n    = NR - int'(cnt_i);
    ready_o   = !block_i && (rank <= free_n);
    stall_o   = !block_i && (rank > free_n);
    n_alloc_o = ready_o ? CW'(rank) : '0;
  end
endmodule

// File: rtl/rob_commit.sv
module rob_commit
  import rob_pkg::*;
#(
  parameter int NR = 16,
  parameter int NB = 4,
  localparam int IW = $clog2(NR),
  localparam int CW = $clog2(NR + 1),
  localparam int BW = $clog2(NB + 1)
) (
  input  rob_entry_t             ent_i [NR],
  input  logic [IW-1:0]          head_i,
  input  logic [CW-1:0]          cnt_i,
  input  logic [NB-1:0]          wb_valid_i,
  input  logic                   flush_i,
  output logic [NB-1:0]          cmt_valid_o,
  output logic [NB-1:0][IW-1:0]  cmt_idx_o,
  output logic [CW-1:0]          n_cmt_o,
  output logic [BW-1:0]          n_wb_o,
  output logic                   mis_o,
  output logic [IW-1:0]          mis_next_o
);
  int  nwb;
  int  ncm;
  logic go;
  logic [IW-1:0] idx;

  always_comb begin
    nwb = 0;
    for (int b = 0; b < NB; b++) if (wb_valid_i[b]) nwb = nwb + 1;
    go         = !flush_i;
    ncm        = 0;
    mis_o      = 1'b0;
    mis_next_o = '0;
    idx        = '0;
    for (int k = 0; k < NB; k++) begin
      idx            = head_i + IW'(k);
      cmt_idx_o[k]   = idx;
      cmt_valid_o[k] = 1'b0;
      if (go && (k < NB - nwb) && (k < int'(cnt_i)) && ent_i[idx].done) begin
        cmt_valid_o[k] = 1'b1;
        ncm = ncm + 1;
        if (ent_i[idx].mis) begin
          mis_o      = 1'b1;
          mis_next_o = idx + 1'b1;
          go         = 1'b0;
        end
      end else begin
        go = 1'b0;
      end
    end
    n_cmt_o = CW'(ncm);
    n_wb_o  = BW'(nwb);
  end
endmodule

// File: rtl/rob_stats.sv
module rob_stats #(
  parameter int NB = 4,
  parameter int NR = 16,
  localparam int BW = $clog2(NB + 1),
  localparam int CW = $clog2(NR + 1)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stall_i,
  input  logic [BW-1:0] n_wb_i,
  input  logic [CW-1:0] n_cmt_i,
  output logic [31:0]   stall_cnt_o,
  output logic [BW-1:0] bus_used_o,
  output logic [31:0]   util_total_o
);
  assign bus_used_o = n_wb_i + BW'(n_cmt_i);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      stall_cnt_o  <= '0;
      util_total_o <= '0;
    end else begin
      if (stall_i) stall_cnt_o <= stall_cnt_o + 32'd1;
      util_total_o <= util_total_o + 32'(bus_used_o);
    end
  end

  assert_stall_count_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall_i |=> stall_cnt_o == $past(stall_cnt_o) + 32'd1);
  assert_stall_hold_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stall_i |=> $stable(stall_cnt_o));
endmodule

// File: rtl/rob_top.sv
module rob_top
  import rob_pkg::*;
#(
  parameter int NR = 16,
  parameter int NW = 4,
  parameter int NB = 4,
  localparam int IW = $clog2(NR),
  localparam int CW = $clog2(NR + 1),
  localparam int BW = $clog2(NB + 1)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     flush_i,
  input  logic [NW-1:0]            disp_valid_i,
  input  logic [NW-1:0][REG_W-1:0] disp_dst_i,
  output logic                     disp_ready_o,
  output logic [NW-1:0][IW-1:0]    disp_tag_o,
  input  logic [NB-1:0]            wb_valid_i,
  input  logic [NB-1:0][IW-1:0]    wb_tag_i,
  input  logic [NB-1:0][DATA_W-1:0] wb_data_i,
  input  logic [NB-1:0]            wb_exc_i,
  input  logic [NB-1:0]            wb_mis_i,
  output logic                     full_o,
  output logic                     empty_o,
  output logic [NB-1:0]            cmt_valid_o,
  output logic [NB-1:0][IW-1:0]    cmt_tag_o,
  output logic [NB-1:0][REG_W-1:0] cmt_dst_o,
  output logic [NB-1:0][DATA_W-1:0] cmt_data_o,
  output logic [NB-1:0]            cmt_exc_o,
  output logic                     redirect_o,
  output logic [31:0]              stall_cnt_o,
  output logic [BW-1:0]            bus_used_o,
  output logic [31:0]              util_total_o
);
  rob_entry_t    ent_q [NR];
  logic [IW-1:0] head_q, tail_q;
  logic [CW-1:0] cnt_q;

  logic [CW-1:0] n_alloc, n_cmt;
  logic [BW-1:0] n_wb;
  logic          stall, mis, block;
  logic [IW-1:0] mis_next;
  logic [NB-1:0][IW-1:0] cmt_idx;

  assign full_o  = (cnt_q == CW'(NR));
  assign empty_o = (cnt_q == '0);

  rob_commit #(.NR(NR), .NB(NB)) u_commit (
    .ent_i      (ent_q),
    .head_i     (head_q),
    .cnt_i      (cnt_q),
    .wb_valid_i (wb_valid_i),
    .flush_i    (flush_i),
    .cmt_valid_o(cmt_valid_o),
    .cmt_idx_o  (cmt_idx),
    .n_cmt_o    (n_cmt),
    .n_wb_o     (n_wb),
    .mis_o      (mis),
    .mis_next_o (mis_next)
  );

  assign redirect_o = mis;
  assign block      = flush_i || mis;

  rob_alloc #(.NR(NR), .NW(NW)) u_alloc (
    .tail_i   (tail_q),
    .cnt_i    (cnt_q),
    .valid_i  (disp_valid_i),
    .block_i  (block),
    .tag_o    (disp_tag_o),
    .n_alloc_o(n_alloc),
    .ready_o  (disp_ready_o),
    .stall_o  (stall)
  );

  rob_stats #(.NB(NB), .NR(NR)) u_stats (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .stall_i     (stall),
    .n_wb_i      (n_wb),
    .n_cmt_i     (n_cmt),
    .stall_cnt_o (stall_cnt_o),
    .bus_used_o  (bus_used_o),
    .util_total_o(util_total_o)
  );

  always_comb begin
    for (int k = 0; k < NB; k++) begin
      cmt_tag_o[k]  = cmt_idx[k];
      cmt_dst_o[k]  = ent_q[cmt_idx[k]].dst;
      cmt_data_o[k] = ent_q[cmt_idx[k]].data;
      cmt_exc_o[k]  = ent_q[cmt_idx[k]].exc;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
      for (int i = 0; i < NR; i++) ent_q[i] <= '0;
    end else begin
      if (flush_i) begin
        tail_q <= head_q;
        cnt_q  <= '0;
      end else if (mis) begin
        head_q <= mis_next;
        tail_q <= mis_next;
        cnt_q  <= '0;
      end else begin
        head_q <= head_q + IW'(n_cmt);
        tail_q <= tail_q + IW'(n_alloc);
        cnt_q  <= cnt_q - n_cmt + n_alloc;
      end
      for (int b = 0; b < NB; b++) begin
        if (wb_valid_i[b]) begin
          ent_q[wb_tag_i[b]].done <= 1'b1;
          ent_q[wb_tag_i[b]].data <= wb_data_i[b];
          ent_q[wb_tag_i[b]].exc  <= wb_exc_i[b];
          ent_q[wb_tag_i[b]].mis  <= wb_mis_i[b];
        end
      end
      if (disp_ready_o) begin
        for (int i = 0; i < NW; i++) begin
          if (disp_valid_i[i]) begin
            ent_q[disp_tag_o[i]].done <= 1'b0;
            ent_q[disp_tag_o[i]].dst  <= disp_dst_i[i];
          end
        end
      end
    end
  end

  // guards
  assert_cnt_bound_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CW'(NR));
  assert_stall_noalloc_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stall |=> tail_q == $past(tail_q));
  assert_flush_empty_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  assert_redirect_empty_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (redirect_o && !flush_i) |=> (empty_o && head_q == tail_q));
  assert_bus_budget_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(n_wb) + 32'(n_cmt)) <= NB);
  assert_no_cmt_empty_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    empty_o |-> cmt_valid_o == '0);

  for (genvar k = 1; k < NB; k++) begin : g_ord
    assert_cmt_contig_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
      cmt_valid_o[k] |-> (cmt_valid_o[k-1] && !ent_q[cmt_idx[k-1]].mis));
  end
endmodule

// File: tb/rob_top_tb_top.sv
module rob_top_tb_top;
  localparam int NR = 8;
  localparam int NW = 4;
  localparam int NB = 3;
  localparam int IW = 3;
  localparam int BW = 2;
  localparam int DW = 32;
  localparam int RW = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #5 clk = ~clk;

  logic                   flush;
  logic [NW-1:0]          dv;
  logic [NW-1:0][RW-1:0]  ddst;
  logic                   dready;
  logic [NW-1:0][IW-1:0]  dtag;
  logic [NB-1:0]          wv;
  logic [NB-1:0][IW-1:0]  wtag;
  logic [NB-1:0][DW-1:0]  wdata;
  logic [NB-1:0]          wexc, wmis;
  logic                   full, empty;
  logic [NB-1:0]          cv;
  logic [NB-1:0][IW-1:0]  ctag;
  logic [NB-1:0][RW-1:0]  cdst;
  logic [NB-1:0][DW-1:0]  cdata;
  logic [NB-1:0]          cexc;
  logic                   redir;
  logic [31:0]            stall_cnt, util_tot;
  logic [BW-1:0]          bus_used;

  rob_top #(.NR(NR), .NW(NW), .NB(NB)) dut_i (
    .clk_i(clk), .rst_ni(rst_n), .flush_i(flush),
    .disp_valid_i(dv), .disp_dst_i(ddst), .disp_ready_o(dready), .disp_tag_o(dtag),
    .wb_valid_i(wv), .wb_tag_i(wtag), .wb_data_i(wdata), .wb_exc_i(wexc), .wb_mis_i(wmis),
    .full_o(full), .empty_o(empty),
    .cmt_valid_o(cv), .cmt_tag_o(ctag), .cmt_dst_o(cdst), .cmt_data_o(cdata), .cmt_exc_o(cexc),
    .redirect_o(redir), .stall_cnt_o(stall_cnt), .bus_used_o(bus_used), .util_total_o(util_tot)
  );

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  // reference state
  bit   m_done [NR];
  bit   m_exc  [NR];
  bit   m_mis  [NR];
  int   m_dst  [NR];
  logic [31:0] m_data [NR];
  int   m_head = 0, m_tail = 0, m_cnt = 0;
  int   m_stall = 0, m_util = 0;

  task automatic chk(string req, string what, longint act, longint exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle();
    flush = 0; dv = '0; ddst = '0; wv = '0; wtag = '0; wdata = '0; wexc = '0; wmis = '0;
  endtask

  // one cycle: inputs already driven at negedge
  task automatic cycle_check();
    int nwb, budget, ncm, need, rank, nx;
    bit go, mis, block, ready, stall;
    int e_tag [NW];
    int c_idx [NB];
    bit c_v [NB];
    #1;
    nwb = 0;
    for (int b = 0; b < NB; b++) if (wv[b]) nwb++;
    budget = NB - nwb;
    go = !flush; ncm = 0; mis = 0; nx = 0;
    for (int k = 0; k < NB; k++) begin
      c_idx[k] = (m_head + k) % NR;
      c_v[k] = 0;
      if (go && k < budget && k < m_cnt && m_done[c_idx[k]]) begin
        c_v[k] = 1; ncm++;
        if (m_mis[c_idx[k]]) begin mis = 1; nx = (c_idx[k] + 1) % NR; go = 0; end
      end else go = 0;
    end
    block = flush || mis;
    need = 0;
    for (int i = 0; i < NW; i++) if (dv[i]) need++;
    ready = !block && need <= NR - m_cnt;
    stall = !block && need > NR - m_cnt;
    rank = 0;
    for (int i = 0; i < NW; i++) begin
      e_tag[i] = (m_tail + rank) % NR;
      if (dv[i]) rank++;
    end

    chk("R4", "empty", empty, m_cnt == 0);
    chk("R4", "full", full, m_cnt == NR);
    chk("R3", "disp_ready", dready, ready);
    chk("R3", "stall_cnt", stall_cnt, m_stall);
    chk("R10", "util_total", util_tot, m_util);
    chk("R10", "bus_used", bus_used, nwb + ncm);
    chk("R8", "redirect", redir, mis);
    for (int i = 0; i < NW; i++)
      if (dv[i] && ready) chk("R2", "disp_tag", dtag[i], e_tag[i]);
    for (int k = 0; k < NB; k++) begin
      chk("R6", "cmt_valid", cv[k], c_v[k]);
      if (c_v[k]) begin
        chk("R7", "cmt_tag", ctag[k], c_idx[k]);
        chk("R7", "cmt_dst", cdst[k], m_dst[c_idx[k]]);
        chk("R5", "cmt_data", cdata[k], m_data[c_idx[k]]);
        chk("R7", "cmt_exc", cexc[k], m_exc[c_idx[k]]);
      end
    end

    // next state
    if (stall) m_stall++;
    m_util += nwb + ncm;
    for (int b = 0; b < NB; b++) if (wv[b]) begin
      m_done[wtag[b]] = 1; m_data[wtag[b]] = wdata[b];
      m_exc[wtag[b]] = wexc[b]; m_mis[wtag[b]] = wmis[b];
    end
    if (ready) for (int i = 0; i < NW; i++) if (dv[i]) begin
      m_done[e_tag[i]] = 0; m_dst[e_tag[i]] = int'(ddst[i]);
    end
    if (flush) begin
      m_tail = m_head; m_cnt = 0;
    end else if (mis) begin
      m_head = nx; m_tail = nx; m_cnt = 0;
    end else begin
      m_head = (m_head + ncm) % NR;
      m_tail = (m_tail + (ready ? need : 0)) % NR;
      m_cnt  = m_cnt - ncm + (ready ? need : 0);
    end
    @(negedge clk);
  endtask

  task automatic drive_random(int disp_pct, int wb_pct, int mis_den, int flush_den);
    int pend[$];
    int j, off;
    idle();
    for (int i = 0; i < NW; i++) begin
      dv[i] = ($urandom % 100) < disp_pct;
      ddst[i] = RW'($urandom);
    end
    for (int o = 0; o < m_cnt; o++) begin
      off = (m_head + o) % NR;
      if (!m_done[off]) pend.push_back(off);
    end
    for (int b = 0; b < NB; b++) begin
      if (pend.size() > 0 && ($urandom % 100) < wb_pct) begin
        j = $urandom % pend.size();
        wv[b] = 1; wtag[b] = IW'(pend[j]); pend.delete(j);
        wdata[b] = $urandom;
        wexc[b] = ($urandom % 8) == 0;
        wmis[b] = ($urandom % mis_den) == 0;
      end
    end
    flush = ($urandom % flush_den) == 0;
  endtask

  initial begin
    idle();
    for (int i = 0; i < NR; i++) begin
      m_done[i] = 0; m_exc[i] = 0; m_mis[i] = 0; m_dst[i] = 0; m_data[i] = '0;
    end
    #23 rst_n = 1;
    @(negedge clk);
    // R1: reset state
    #1;
    chk("R1", "empty", empty, 1);
    chk("R1", "full", full, 0);
    chk("R1", "disp_ready", dready, 1);
    chk("R1", "cmt_valid", cv, 0);
    chk("R1", "stall_cnt", stall_cnt, 0);
    chk("R1", "bus_used", bus_used, 0);
    chk("R1", "util_total", util_tot, 0);
    @(negedge clk);

    // directed: fill to full, then a stalled group (R3, R4)
    idle(); dv = 4'b1111; cycle_check();
    idle(); dv = 4'b0101; ddst = {5'd3, 5'd2, 5'd1, 5'd0}; cycle_check();
    idle(); dv = 4'b0011; cycle_check();
    idle(); dv = 4'b0001; cycle_check();
    chk("R4", "full after 8", full, 1);
    // writeback on all buses: commit gets no lane (R6)
    idle(); wv = 3'b111; wtag = {3'd2, 3'd1, 3'd0}; wdata = {32'd30, 32'd20, 32'd10}; cycle_check();
    idle(); wv = 3'b011; wtag = {3'd0, 3'd4, 3'd3}; wdata = {32'd0, 32'd40, 32'd33}; cycle_check();
    // branch at tag 5 mispredicted
    idle(); wv = 3'b001; wtag = {3'd0, 3'd0, 3'd5}; wmis = 3'b001; cycle_check();
    idle(); cycle_check();
    idle(); cycle_check();
    chk("R8", "empty after redirect", empty, 1);
    // flush on a partly full ring (R9)
    idle(); dv = 4'b0011; cycle_check();
    idle(); flush = 1; dv = 4'b0001; cycle_check();
    chk("R9", "empty after flush", empty, 1);

    // mixed random phases
    for (int c = 0; c < 6000; c++) begin
      if ((c / 300) % 2 == 0) drive_random(70, 30, 15, 150);
      else drive_random(15, 90, 10, 200);
      cycle_check();
    end
    idle(); #1;
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule